// File: doc/BRIEF.md
# Port Partition Controller

This block watches one switch port for signs of a broken segment and, when they appear, takes the port out of normal operation. A port is isolated ("partitioned") either when every one of a run of consecutive retransmissions of one frame collides, or when a single collision stays on the wire for too long. While isolated, the port stops accepting received frames. It also tells its transmit logic to send every pending frame straight through, with collisions and backoff ignored, so that its transmit buffers drain instead of starving the other ports.

The port returns to normal service once it completes a transmission whose opening window of bit times was free of collisions. Entry and exit each produce a maskable one-cycle interrupt pulse and update a cause bit. Two LED drives show the state: one lamp lit solid and a status lamp that double-blinks. Partitioning works only while a global enable is set, and that enable is off after reset.

Top module: `portPartition`

## Requirements
- R1: With `partEn` low the port never partitions, whatever collisions occur; `partEn` is expected low after reset, and all outputs are 0 in reset.
- R2: With `partEn` high, the port partitions on the clock edge after the `txEnd` of the 32nd consecutive attempt that collided. An attempt runs from a `txStart` pulse to a `txEnd` pulse, and it collided if `colDet` was high on any cycle from the one after `txStart` up to and including `txEnd`.
- R3: The consecutive-collision count restarts at zero when an attempt ends without a collision. It also restarts when a `txStart` arrives with `txRetry` low (a new frame), so that attempt counts as the first.
- R4: With `partEn` high, the port partitions when `colDet` stays high through more than 2048 `bitTick` pulses. This happens on the edge that takes the 2049th tick; after exactly 2048 ticks the port is not partitioned. The duration count restarts whenever `colDet` drops.
- R5: While partitioned, `rxInhibit` and `colIgnore` are both 1; otherwise both are 0.
- R6: A partitioned port returns to normal on the edge after the `txEnd` of an attempt that saw no `colDet` during its first 512 `bitTick` pulses. A collision after the 512th tick does not prevent the exit; a collision before it keeps the port partitioned.
- R7: On entry, `intCause` goes to 1 on the same edge as `partitioned`. `intEntry` is high for exactly that one cycle, but only if `intMask` was low when entry was decided.
- R8: On a healthy exit (R6), `intCause` clears on the same edge. `intExit` pulses for one cycle unless `intMask` was high.
- R9: Dropping `partEn` while partitioned returns the port to normal on the next edge, clears `intCause` and raises no interrupt.
- R10: While partitioned, `ledPart` is 1 and `ledStatus` follows an 8-phase cycle that advances on each `slowTick`: it is on in phases 0 and 2 and off in phases 1 and 3 to 7. Phase 0 begins on entry. When not partitioned, both LEDs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| partEn | input | 1 | Global partition enable |
| colDet | input | 1 | Collision detected on the wire |
| txStart | input | 1 | Pulse: a transmit attempt begins |
| txRetry | input | 1 | With txStart: attempt is a retry of the same frame |
| txEnd | input | 1 | Pulse: the transmit attempt ends |
| bitTick | input | 1 | One pulse per bit time of this port |
| slowTick | input | 1 | Free-running slow tick for LED blinking |
| intMask | input | 1 | Masks both interrupt pulses |
| partitioned | output | 1 | Port is partitioned |
| rxInhibit | output | 1 | Refuse received frames |
| colIgnore | output | 1 | Transmit ignores collisions and skips backoff |
| intEntry | output | 1 | One-cycle entry interrupt |
| intExit | output | 1 | One-cycle exit interrupt |
| intCause | output | 1 | Per-port partition cause bit |
| ledPart | output | 1 | Dedicated partition LED |
| ledStatus | output | 1 | Status LED, double-blink while partitioned |

## Verification
A stale collision count would show up as partition arriving one attempt early or late, so the bench checks `partitioned` both after the 31st and after the 32nd collided attempt. A duration counter that fails to clear, or one that is off by one, moves entry away from the 2049th tick edge, and this is visible the cycle after that tick. An exit window that closes early or late would let an early collision end the partition, or keep a clean transmission from ending it. This shows at `txEnd` plus one edge. Phase errors in the blink generator appear on `ledStatus` within one `slowTick`.

// File: rtl/partPkg.sv
package partPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrEntry;    // hold the entry-detection counters at zero
    logic partActive;  // port is partitioned
  } ctlStrobeT;

  // events from datapath to control
  typedef struct packed {
    logic retryTrip;   // consecutive collided attempt limit reached
    logic longTrip;    // collision outlasted its limit
    logic cleanDone;   // attempt finished with a clean opening window
  } dpEventT;

  typedef enum logic {ST_NORMAL = 1'b0, ST_PART = 1'b1} partStateT;
endpackage

// File: rtl/partDatapath.sv
module partDatapath
  import partPkg::*;
#(
  parameter int RETRY_LIMIT = 32,
  parameter int LONG_COL    = 2048,
  parameter int WINDOW      = 512,
  parameter int BLINK_LEN   = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      colDet,
  input  logic      txStart,
  input  logic      txRetry,
  input  logic      txEnd,
  input  logic      bitTick,
  input  logic      slowTick,
  input  ctlStrobeT strb,
  output dpEventT   evt,
  output logic      blinkOn
);
  localparam int RW = $clog2(RETRY_LIMIT + 1);
  localparam int DW = $clog2(LONG_COL + 2);
  localparam int WW = $clog2(WINDOW + 1);
  localparam int BW = (BLINK_LEN > 1) ? $clog2(BLINK_LEN) : 1;
  localparam logic [RW-1:0] RETRY_LAST = RW'(RETRY_LIMIT - 1);
  localparam logic [RW-1:0] RETRY_MAX  = RW'(RETRY_LIMIT);
  localparam logic [DW-1:0] DUR_TRIP   = DW'(LONG_COL);
  localparam logic [DW-1:0] DUR_MAX    = DW'(LONG_COL + 1);
  localparam logic [WW-1:0] WIN_END    = WW'(WINDOW);
  localparam logic [BW-1:0] BLINK_LAST = BW'(BLINK_LEN - 1);

  logic          attActive, attColl, winClean;
  logic [RW-1:0] retryCnt;
  logic [DW-1:0] durCnt;
  logic [WW-1:0] winCnt;
  logic [BW-1:0] blinkPhase;
  logic          collidedNow, inWindow;

  assign collidedNow = attColl | colDet;
  assign inWindow    = (winCnt < WIN_END);

  // attempt tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attActive <= 1'b0;
      attColl   <= 1'b0;
    end else begin
      if (txStart)      attActive <= 1'b1;
      else if (txEnd)   attActive <= 1'b0;
      if (txStart)                  attColl <= 1'b0;
      else if (colDet && attActive) attColl <= 1'b1;
    end
  end

  // consecutive collided attempts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCnt <= '0;
    end else if (strb.clrEntry) begin
      retryCnt <= '0;
    end else if (txStart && !txRetry) begin
      retryCnt <= '0;
    end else if (txEnd && attActive) begin
      if (!collidedNow)              retryCnt <= '0;
      else if (retryCnt != RETRY_MAX) retryCnt <= retryCnt + 1'b1;
    end
  end

  // collision duration in bit times
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      durCnt <= '0;
    end else if (strb.clrEntry || !colDet) begin
      durCnt <= '0;
    end else if (bitTick && durCnt != DUR_MAX) begin
      durCnt <= durCnt + 1'b1;
    end
  end

  // opening window of the current attempt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt   <= '0;
      winClean <= 1'b0;
    end else if (txStart) begin
      winCnt   <= '0;
      winClean <= 1'b1;
    end else if (attActive) begin
      if (colDet && inWindow)  winClean <= 1'b0;
      if (bitTick && inWindow) winCnt   <= winCnt + 1'b1;
    end
  end

  // blink phase generator
  generate
    if (BLINK_LEN > 1) begin : g_blink
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 blinkPhase <= '0;
        else if (!strb.partActive) blinkPhase <= '0;
        else if (slowTick)         blinkPhase <= (blinkPhase == BLINK_LAST) ? '0 : blinkPhase + 1'b1;
      end
    end else begin : g_noBlink
      assign blinkPhase = '0;
    end
  endgenerate

  assign blinkOn = (blinkPhase == BW'(0)) || (blinkPhase == BW'(2));

  assign evt.retryTrip = !strb.clrEntry && attActive && txEnd && collidedNow
                         && (retryCnt == RETRY_LAST);
  assign evt.longTrip  = !strb.clrEntry && colDet && bitTick && (durCnt == DUR_TRIP);
  assign evt.cleanDone = strb.partActive && attActive && txEnd && winClean
                         && !(colDet && inWindow);

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEntry |=> (retryCnt == '0) && (durCnt == '0)); // R1
  AST_DUR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !colDet |=> (durCnt == '0)); // R4
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (txEnd && attActive && !collidedNow) |=> (retryCnt == '0)); // R3
endmodule

// File: rtl/partControl.sv
module partControl
  import partPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      partEn,
  input  logic      intMask,
  input  dpEventT   evt,
  output ctlStrobeT strb,
  output logic      partitioned,
  output logic      intEntry,
  output logic      intExit,
  output logic      intCause
);
  partStateT state, stateNext;
  logic enterNow, healthyExit, forcedExit;

  assign enterNow    = (state == ST_NORMAL) && partEn && (evt.retryTrip || evt.longTrip);
  assign forcedExit  = (state == ST_PART) && !partEn;
  assign healthyExit = (state == ST_PART) && partEn && evt.cleanDone;

  always_comb begin
    stateNext = state;
    if (enterNow)                        stateNext = ST_PART;
    else if (forcedExit || healthyExit)  stateNext = ST_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_NORMAL;
      intEntry <= 1'b0;
      intExit  <= 1'b0;
      intCause <= 1'b0;
    end else begin
      state    <= stateNext;
      intEntry <= enterNow && !intMask;
      intExit  <= healthyExit && !intMask;
      if (enterNow)                        intCause <= 1'b1;
      else if (forcedExit || healthyExit)  intCause <= 1'b0;
    end
  end

  assign partitioned     = (state == ST_PART);
  assign strb.partActive = (state == ST_PART);
  assign strb.clrEntry   = !partEn || (state == ST_PART);

  AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !partEn |=> !partitioned); // R1
  AST_ENTRY_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(partitioned) |-> (intEntry == !$past(intMask)) && intCause); // R7
  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(partitioned) |-> !intCause); // R8
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intEntry, intExit})); // R7
  AST_FORCED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (partitioned && !partEn) |=> !intExit); // R9
endmodule

// File: rtl/portPartition.sv
module portPartition
  import partPkg::*;
#(
  parameter int RETRY_LIMIT = 32,
  parameter int LONG_COL    = 2048,
  parameter int WINDOW      = 512,
  parameter int BLINK_LEN   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic partEn,
  input  logic colDet,
  input  logic txStart,
  input  logic txRetry,
  input  logic txEnd,
  input  logic bitTick,
  input  logic slowTick,
  input  logic intMask,
  output logic partitioned,
  output logic rxInhibit,
  output logic colIgnore,
  output logic intEntry,
  output logic intExit,
  output logic intCause,
  output logic ledPart,
  output logic ledStatus
);
  ctlStrobeT strb;
  dpEventT   evt;
  logic      blinkOn;

  partDatapath #(
    .RETRY_LIMIT(RETRY_LIMIT), .LONG_COL(LONG_COL),
    .WINDOW(WINDOW), .BLINK_LEN(BLINK_LEN)
  ) i_dp (
    .clk(clk), .rstN(rstN), .colDet(colDet), .txStart(txStart),
    .txRetry(txRetry), .txEnd(txEnd), .bitTick(bitTick),
    .slowTick(slowTick), .strb(strb), .evt(evt), .blinkOn(blinkOn)
  );

  partControl i_ctl (
    .clk(clk), .rstN(rstN), .partEn(partEn), .intMask(intMask),
    .evt(evt), .strb(strb), .partitioned(partitioned),
    .intEntry(intEntry), .intExit(intExit), .intCause(intCause)
  );

  assign rxInhibit = partitioned;
  assign colIgnore = partitioned;
  assign ledPart   = partitioned;
  assign ledStatus = partitioned && blinkOn;

  AST_LED_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !partitioned |-> !ledStatus && !ledPart); // R10
endmodule

// File: tb/test_portPartition.sv
module test_portPartition;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic partEn = 0, colDet = 0, txStart = 0, txRetry = 0, txEnd = 0;
  logic bitTick = 0, slowTick = 0, intMask = 0;
  logic partitioned, rxInhibit, colIgnore, intEntry, intExit, intCause, ledPart, ledStatus;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  portPartition i_portPartition (
    .clk(clk), .rstN(rstN), .partEn(partEn), .colDet(colDet),
    .txStart(txStart), .txRetry(txRetry), .txEnd(txEnd), .bitTick(bitTick),
    .slowTick(slowTick), .intMask(intMask), .partitioned(partitioned),
    .rxInhibit(rxInhibit), .colIgnore(colIgnore), .intEntry(intEntry),
    .intExit(intExit), .intCause(intCause), .ledPart(ledPart), .ledStatus(ledStatus)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one transmit attempt; collision (if any) after 'ticks' bit ticks
  task automatic attempt(input logic retry, input logic coll, input int ticks);
    @(negedge clk); txStart = 1; txRetry = retry;
    @(negedge clk); txStart = 0; txRetry = 0;
    for (int i = 0; i < ticks; i++) begin bitTick = 1; @(negedge clk); end
    bitTick = 0;
    if (coll) begin colDet = 1; @(negedge clk); @(negedge clk); colDet = 0; end
    txEnd = 1;
    @(negedge clk); txEnd = 0;
  endtask

  task automatic collidedRun(input int n, input logic firstNew);
    for (int i = 0; i < n; i++) attempt((i == 0 && firstNew) ? 1'b0 : 1'b1, 1'b1, 2);
  endtask

  task automatic doReset();
    rstN = 0; partEn = 0; intMask = 0;
    repeat (2) @(negedge clk);
    rstN = 1; @(negedge clk);
  endtask

  task automatic testReset();
    check("R1", "partitioned in reset", partitioned, 1'b0);
    check("R1", "intCause in reset", intCause, 1'b0);
    check("R10", "ledStatus in reset", ledStatus, 1'b0);
  endtask

  task automatic testDisabled();
    collidedRun(40, 1'b1);
    check("R1", "no partition while disabled", partitioned, 1'b0);
    check("R5", "rxInhibit normal", rxInhibit, 1'b0);
  endtask

  task automatic testRetryEntry();
    partEn = 1;
    collidedRun(31, 1'b1);
    attempt(1'b1, 1'b0, 2);                  // clean retry restarts count
    collidedRun(20, 1'b0);
    collidedRun(31, 1'b1);                   // new frame restarts, 31 total
    check("R3", "31 after restart", partitioned, 1'b0);
    attempt(1'b1, 1'b1, 2);                  // 32nd
    check("R2", "partition after 32", partitioned, 1'b1);
    check("R7", "intEntry pulse", intEntry, 1'b1);
    check("R7", "cause set", intCause, 1'b1);
    check("R5", "rxInhibit", rxInhibit, 1'b1);
    check("R5", "colIgnore", colIgnore, 1'b1);
    check("R10", "ledPart on", ledPart, 1'b1);
    check("R10", "blink phase0 on", ledStatus, 1'b1);
    @(negedge clk);
    check("R7", "intEntry one cycle", intEntry, 1'b0);
  endtask

  task automatic testBlink();
    logic expOn;
    for (int p = 1; p <= 10; p++) begin
      slowTick = 1; @(negedge clk); slowTick = 0;
      expOn = ((p % 8) == 0) || ((p % 8) == 2);
      check("R10", $sformatf("blink phase %0d", p % 8), ledStatus, expOn);
    end
  endtask

  task automatic testExit(input logic masked);
    intMask = masked;
    attempt(1'b0, 1'b1, 100);                // collision inside window
    check("R6", "stay after early collision", partitioned, 1'b1);
    attempt(1'b0, 1'b1, 512);                // collision after window
    check("R6", "exit after clean window", partitioned, 1'b0);
    check("R8", "intExit", intExit, !masked);
    check("R8", "cause cleared", intCause, 1'b0);
    check("R5", "colIgnore cleared", colIgnore, 1'b0);
    @(negedge clk);
    check("R8", "intExit one cycle", intExit, 1'b0);
    intMask = 0;
  endtask

  task automatic testLongCollision();
    intMask = 1;
    colDet = 1; bitTick = 1;
    repeat (300) @(negedge clk);
    colDet = 0; @(negedge clk);              // drop restarts the count
    colDet = 1;
    repeat (2048) @(negedge clk);
    check("R4", "not after 2048 ticks", partitioned, 1'b0);
    @(negedge clk); bitTick = 0; colDet = 0;
    check("R4", "partition on 2049th tick", partitioned, 1'b1);
    check("R7", "masked intEntry", intEntry, 1'b0);
    check("R7", "cause set when masked", intCause, 1'b1);
    intMask = 0;
  endtask

  task automatic testForcedExit();
    partEn = 0; @(negedge clk);
    check("R9", "forced exit", partitioned, 1'b0);
    check("R9", "no intExit", intExit, 1'b0);
    check("R9", "cause cleared", intCause, 1'b0);
    check("R10", "ledPart off", ledPart, 1'b0);
    partEn = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    testReset();
    testDisabled();
    testRetryEntry();
    testBlink();
    testExit(1'b0);
    testLongCollision();
    testExit(1'b1);
    testLongCollision();
    testForcedExit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule